// File: doc/BRIEF.md
# BCD-Set Pulse Width Modulator

This block generates a pulse width modulated output whose duty cycle is chosen by a two-digit decimal setting. Each digit is given in BCD, as a thumbwheel switch would supply it. Inside, a two-decade BCD up counter steps once per clock and forms a ramp from 00 to 99.

A tens-then-units magnitude compare of the ramp against the setting drives the output. The output is high for the first S counts of each 100-clock period, where S is the setting. A second output always carries the inverse level.

The setting is taken into the block only when the ramp wraps, or while reset is held. Because of this, a change made mid-period never cuts a pulse short. Digits above nine are clamped to nine. The setting 99 is taken as full scale, so the duty range runs from 1% (setting 01) up to 100% (setting 99), and 00 gives a steady low.

Top module: `bcd_pwm`

## Requirements
- R1: `ramp_tens`/`ramp_units` form a BCD count that rises by one decimal step on every clock; each digit stays within 0..9.
- R2: After 99 the ramp returns to 00 on the next clock, so the period is 100 clocks.
- R3: With an active setting S between 01 and 98, `pwm_out` is high exactly while the ramp value is below S. That gives S high clocks per period, starting at ramp 00. For example, setting 01 gives one high clock.
- R4: An active setting of 00 keeps `pwm_out` low for the whole period.
- R5: An active setting of 99 keeps `pwm_out` high for the whole period (100% duty).
- R6: `pwm_n_out` is at all times the logical inverse of `pwm_out`.
- R7: The setting inputs are copied into the active setting only on the clock where the ramp wraps from 99 to 00, or while reset is high. A change elsewhere has no effect on the output until the next wrap.
- R8: A setting digit above 9 is treated as 9. For example, tens 12 with units 5 acts as 95, and tens 4 with units 15 acts as 49.
- R9: `rst` is synchronous and active high: the clock edge that samples it sets the ramp to 00 and loads the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ramp advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_tens | input | 4 | BCD tens digit of the duty setting |
| set_units | input | 4 | BCD units digit of the duty setting |
| ramp_tens | output | 4 | Tens digit of the ramp counter |
| ramp_units | output | 4 | Units digit of the ramp counter |
| pwm_out | output | 1 | Pulse width modulated output |
| pwm_n_out | output | 1 | Inverse of `pwm_out` |

## Verification
A units digit that skips, or a tens carry taken at the wrong count, shows on the ramp outputs at the next clock. It also moves the falling edge of `pwm_out` within the same period.

An active setting that is loaded at the wrong moment shows up within one period. Either the pulse width changes in the middle of a period, or a new width appears one period late.

A fault in the tens-then-units compare, or in the digit clamp, shows as a high count per period that is wrong by at least one clock. Because every period is counted in full, any such fault is found within 100 clocks.

// File: rtl/bcd_pwm.sv
module bcd_pwm #(
  parameter int DW = 4,
  parameter int DMAX = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_tens,
  input  logic [DW-1:0] set_units,
  output logic [DW-1:0] ramp_tens,
  output logic [DW-1:0] ramp_units,
  output logic          pwm_out,
  output logic          pwm_n_out
);
  localparam logic [DW-1:0] TOP = DW'(DMAX);
  localparam int VW = 2 * DW;

  logic [DW-1:0] cnt_t, cnt_u, act_t, act_u;
  logic [DW-1:0] in_t, in_u;
  logic wrap, below, full;

  assign in_t = (set_tens  > TOP) ? TOP : set_tens;
  assign in_u = (set_units > TOP) ? TOP : set_units;
  assign wrap = (cnt_t == TOP) && (cnt_u == TOP);

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      cnt_t <= '0;
      cnt_u <= '0;
      act_t <= in_t;
      act_u <= in_u;
    end else if (cnt_u == TOP) begin
      cnt_u <= '0;
      cnt_t <= cnt_t + 1'b1;
    end else begin
      cnt_u <= cnt_u + 1'b1;
    end
  end

  assign below = (cnt_t < act_t) || ((cnt_t == act_t) && (cnt_u < act_u));
  assign full  = (act_t == TOP) && (act_u == TOP);

  assign pwm_out    = below || full;
  assign pwm_n_out  = ~pwm_out;
  assign ramp_tens  = cnt_t;
  assign ramp_units = cnt_u;

  logic [VW-1:0] ramp_val, act_val;
  assign ramp_val = VW'(cnt_t) * VW'(DMAX + 1) + VW'(cnt_u);
  assign act_val  = VW'(act_t) * VW'(DMAX + 1) + VW'(act_u);

  assert_digits_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_t <= TOP) && (cnt_u <= TOP));
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ramp_val == $past(ramp_val) + VW'(1));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ramp_val == '0);
  assert_rise_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> ramp_val == '0);
  assert_fall_at_set_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_out) |-> ramp_val == act_val);
  assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
    (act_val == '0) |-> !pwm_out);
  assert_hold_set_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_val));
  assert_clamped_R8: assert property (@(posedge clk) disable iff (rst)
    (act_t <= TOP) && (act_u <= TOP));
endmodule

// File: tb/tb_bcd_pwm.sv
module tb_bcd_pwm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] set_tens = 4'd0, set_units = 4'd0;
  logic [3:0] ramp_tens, ramp_units;
  logic pwm_out, pwm_n_out;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  bcd_pwm dut (.clk, .rst, .set_tens, .set_units, .ramp_tens, .ramp_units,
               .pwm_out, .pwm_n_out);

  // {tens, units, expected high clocks per period}
  localparam logic [14:0] VEC [0:8] = '{
    {4'd0,  4'd0,  7'd0},    // R4
    {4'd0,  4'd1,  7'd1},    // R3 one clock
    {4'd5,  4'd0,  7'd50},   // R3
    {4'd3,  4'd7,  7'd37},   // R3 units compare
    {4'd9,  4'd8,  7'd98},   // R3
    {4'd9,  4'd9,  7'd100},  // R5
    {4'd12, 4'd5,  7'd95},   // R8 tens clamp
    {4'd4,  4'd15, 7'd49},   // R8 units clamp
    {4'd15, 4'd15, 7'd100}   // R8 both clamp, full
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rv();
    return int'(ramp_tens) * 10 + int'(ramp_units);
  endfunction

  task automatic wait_zero();
    @(negedge clk);
    while (rv() != 0) @(negedge clk);
  endtask

  // expects to be called at a negedge with ramp 00
  task automatic measure(input int exp, input string req);
    int highs = 0;
    bit shape = 1'b1, seq = 1'b1, inv = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (rv() != i) seq = 1'b0;
      if (pwm_out !== (i < exp)) shape = 1'b0;
      if (pwm_n_out !== ~pwm_out) inv = 1'b0;
      if (pwm_out === 1'b1) highs++;
      @(negedge clk);
    end
    check(highs == exp, req, highs, exp);
    check(shape, req, int'(shape), 1);
    check(seq, "R1 ramp sequence", int'(seq), 1);
    check(inv, "R6 inverse output", int'(inv), 1);
    check(rv() == 0, "R2 wrap to 00", rv(), 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9 reset state, setting loaded during reset
    set_tens = 4'd2; set_units = 4'd0;
    repeat (3) @(negedge clk);
    check(rv() == 0, "R9 ramp at reset", rv(), 0);
    check(pwm_out === 1'b1, "R9 setting loaded in reset", int'(pwm_out), 1);
    rst = 1'b0;
    measure(20, "R9 first period");

    for (int k = 0; k < 9; k++) begin
      set_tens = VEC[k][14:11];
      set_units = VEC[k][10:7];
      wait_zero();
      measure(int'(VEC[k][6:0]), "R3/R4/R5/R8 duty vector");
    end

    // R7: change mid-period is ignored until wrap
    set_tens = 4'd5; set_units = 4'd0;
    wait_zero();
    repeat (10) @(negedge clk);
    set_tens = 4'd8; set_units = 4'd0;
    begin
      int highs = 10;
      for (int i = 10; i < 100; i++) begin
        if (pwm_out === 1'b1) highs++;
        @(negedge clk);
      end
      check(highs == 50, "R7 old setting held", highs, 50);
    end
    measure(80, "R7 new setting after wrap");

    // R9 mid-run reset
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(rv() == 0, "R9 mid-run reset", rv(), 0);
    set_tens = 4'd0; set_units = 4'd3;
    @(negedge clk);
    rst = 1'b0;
    measure(3, "R9 setting after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule